// File: doc/BRIEF.md
# Programmable Video Sync Timing Generator

This block produces the line and frame sync timing for a 640x480 picture in the pixel clock domain. A column counter runs across each line and wraps at a programmable line length. A row counter advances once per line and wraps at the frame height. Horizontal sync is high while the column lies inside a programmable window. Vertical sync is high while the row lies inside a second programmable window. A pixel enable marks the columns that carry picture data: these are the sync-window columns on the rows of the active band that follows the vertical pulse. The current column and row are also brought out, so that downstream pixel logic can address its data.

Each sync edge position is 10 bits wide. It is built from a dedicated 8-bit low register plus a 2-bit slice of one shared high register. A plain write strobe with address and data loads these registers into a staging copy. The staging copy becomes the working copy only when a new frame begins, so a frame never mixes two timings. With the default parameters, horizontal sync spans columns 48 to 687 (640 columns) of a 780-column line. Vertical sync spans rows 3 and 4 of a 525-row frame, and the 480 active rows follow it.

Top module: `vsg_timing_gen`

## Requirements
- R1: `col` counts up by one on every clock and returns to 0 after reaching L-1. L is the line length {reg 6 bits [1:0], reg 5}; its default is 780.
- R2: `row` advances by one each time `col` wraps, and returns to 0 after row FRAME_ROWS-1 (default 525).
- R3: `hsync` is high exactly when HR <= col < HF. HR is {reg 4 bits [7:6], reg 0} and HF is {reg 4 bits [5:4], reg 1}; the defaults are 48 and 688.
- R4: `vsync` is high exactly when VR <= row < VF. VR is {reg 4 bits [3:2], reg 2} and VF is {reg 4 bits [1:0], reg 3}; the defaults are 3 and 5.
- R5: `pix_en` is high exactly when `hsync` is high and VF <= row < VF + ACTIVE_ROWS (default 480).
- R6: A write (`wr_en` high, `wr_addr`, `wr_data`) goes to a staging copy. The staging copy takes effect on the clock where `col` and `row` both return to 0. A write to address 7 changes nothing.
- R7: If a programmed falling position is not greater than its rising position, that sync output stays low for the whole frame.
- R8: While `rst` is high, and on the first clock after it falls, `col` and `row` are 0. Reset restores every position and the line length to its default, in both the staging and working copies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0..6 used) |
| wr_data | input | 8 | Register write data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| pix_en | output | 1 | Active-pixel enable |
| col | output | 10 | Current column |
| row | output | 10 | Current row |

## Verification
The bench builds the block with a 16-row frame, an 8-row active band, and a default line of 40 columns, with horizontal sync from column 4 to 36 and vertical sync on rows 3 to 4. With these values a frame lasts a few hundred clocks. Many frame boundaries, staging-to-working reloads and random reprogrammings of every register therefore fit in one run, and each is compared cycle by cycle against a bench model. The bench also programs a 1000-column line with edges above 255, which drives the upper 2-bit fields of the shared register.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
    localparam int POS_W  = 10;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int HI_W   = POS_W - DATA_W;

    typedef enum logic [ADDR_W-1:0] {
        REG_HS_ON_LO  = 3'd0,
        REG_HS_OFF_LO = 3'd1,
        REG_VS_ON_LO  = 3'd2,
        REG_VS_OFF_LO = 3'd3,
        REG_EDGE_HI   = 3'd4,
        REG_LINE_LO   = 3'd5,
        REG_LINE_HI   = 3'd6,
        REG_SPARE     = 3'd7
    } vsg_addr_e;

    typedef struct packed {
        logic [POS_W-1:0] hs_on;
        logic [POS_W-1:0] hs_off;
        logic [POS_W-1:0] vs_on;
        logic [POS_W-1:0] vs_off;
        logic [POS_W-1:0] line_len;
    } vsg_cfg_t;

    typedef struct packed {
        vsg_cfg_t stg;
        vsg_cfg_t act;
    } vsg_reg_state_t;

    typedef struct packed {
        logic [POS_W-1:0] col;
        logic [POS_W-1:0] row;
    } vsg_cnt_state_t;
endpackage

// File: rtl/vsg_regs.sv
module vsg_regs
    import vsg_pkg::*;
#(
    parameter vsg_cfg_t DEF_CFG = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_start,
    output vsg_cfg_t          cfg
);
    vsg_reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // working copy picks up the staging copy as it stood before this clock
        if (frame_start) st_d.act = st_q.stg;
        if (wr_en) begin
            case (vsg_addr_e'(wr_addr))
                REG_HS_ON_LO:  st_d.stg.hs_on[DATA_W-1:0]    = wr_data;
                REG_HS_OFF_LO: st_d.stg.hs_off[DATA_W-1:0]   = wr_data;
                REG_VS_ON_LO:  st_d.stg.vs_on[DATA_W-1:0]    = wr_data;
                REG_VS_OFF_LO: st_d.stg.vs_off[DATA_W-1:0]   = wr_data;
                REG_EDGE_HI: begin
                    st_d.stg.hs_on[POS_W-1:DATA_W]  = wr_data[4*HI_W-1 -: HI_W];
                    st_d.stg.hs_off[POS_W-1:DATA_W] = wr_data[3*HI_W-1 -: HI_W];
                    st_d.stg.vs_on[POS_W-1:DATA_W]  = wr_data[2*HI_W-1 -: HI_W];
                    st_d.stg.vs_off[POS_W-1:DATA_W] = wr_data[HI_W-1:0];
                end
                REG_LINE_LO:   st_d.stg.line_len[DATA_W-1:0]     = wr_data;
                REG_LINE_HI:   st_d.stg.line_len[POS_W-1:DATA_W] = wr_data[HI_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.stg <= DEF_CFG;
            st_q.act <= DEF_CFG;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.act;
endmodule

// File: rtl/vsg_counters.sv
module vsg_counters
    import vsg_pkg::*;
#(
    parameter int FRAME_ROWS = 525
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [POS_W-1:0] line_len,
    output logic [POS_W-1:0] col,
    output logic [POS_W-1:0] row,
    output logic             frame_start
);
    localparam logic [POS_W-1:0] LAST_ROW = POS_W'(FRAME_ROWS - 1);

    vsg_cnt_state_t cnt_d, cnt_q;
    logic [POS_W:0] col_inc;
    logic           line_end;
    logic           row_end;

    always_comb begin
        col_inc  = {1'b0, cnt_q.col} + 1'b1;
        // a length of 0 or 1 behaves as a one-column line
        line_end = col_inc >= {1'b0, line_len};
        row_end  = cnt_q.row == LAST_ROW;
        cnt_d    = cnt_q;
        if (line_end) begin
            cnt_d.col = '0;
            cnt_d.row = row_end ? '0 : cnt_q.row + 1'b1;
        end else begin
            cnt_d.col = col_inc[POS_W-1:0];
        end
        frame_start = line_end && row_end;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign col = cnt_q.col;
    assign row = cnt_q.row;
endmodule

// File: rtl/vsg_decode.sv
module vsg_decode
    import vsg_pkg::*;
#(
    parameter int ACTIVE_ROWS = 480
) (
    input  logic [POS_W-1:0] col,
    input  logic [POS_W-1:0] row,
    input  vsg_cfg_t         cfg,
    output logic             hsync,
    output logic             vsync,
    output logic             pix_en
);
    localparam logic [POS_W:0] BAND_LEN = (POS_W+1)'(ACTIVE_ROWS);

    logic [POS_W:0] band_end;
    logic           in_band;

    always_comb begin
        // an empty window (off <= on) can never satisfy both bounds
        hsync    = (col >= cfg.hs_on) && (col < cfg.hs_off);
        vsync    = (row >= cfg.vs_on) && (row < cfg.vs_off);
        band_end = {1'b0, cfg.vs_off} + BAND_LEN;
        in_band  = (row >= cfg.vs_off) && ({1'b0, row} < band_end);
        pix_en   = hsync && in_band;
    end
endmodule

// File: rtl/vsg_timing_gen.sv
module vsg_timing_gen
    import vsg_pkg::*;
#(
    parameter int FRAME_ROWS  = 525,
    parameter int ACTIVE_ROWS = 480,
    parameter int DEF_LINE    = 780,
    parameter int DEF_HS_ON   = 48,
    parameter int DEF_HS_OFF  = 688,
    parameter int DEF_VS_ON   = 3,
    parameter int DEF_VS_OFF  = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    output logic        hsync,
    output logic        vsync,
    output logic        pix_en,
    output logic [9:0]  col,
    output logic [9:0]  row
);
    localparam vsg_cfg_t DEF_CFG = '{
        hs_on:    POS_W'(DEF_HS_ON),
        hs_off:   POS_W'(DEF_HS_OFF),
        vs_on:    POS_W'(DEF_VS_ON),
        vs_off:   POS_W'(DEF_VS_OFF),
        line_len: POS_W'(DEF_LINE)
    };

    vsg_cfg_t sh_cfg;
    logic     frame_start;

    vsg_regs #(.DEF_CFG(DEF_CFG)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .frame_start (frame_start),
        .cfg         (sh_cfg)
    );

    vsg_counters #(.FRAME_ROWS(FRAME_ROWS)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .line_len    (sh_cfg.line_len),
        .col         (col),
        .row         (row),
        .frame_start (frame_start)
    );

    vsg_decode #(.ACTIVE_ROWS(ACTIVE_ROWS)) u_dec (
        .col    (col),
        .row    (row),
        .cfg    (sh_cfg),
        .hsync  (hsync),
        .vsync  (vsync),
        .pix_en (pix_en)
    );
endmodule

// File: rtl/vsg_checker.sv
module vsg_checker
    import vsg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [POS_W-1:0] col,
    input logic [POS_W-1:0] row,
    input logic             hsync,
    input logic             vsync,
    input logic             pix_en,
    input vsg_cfg_t         sh
);
    a_r1_col_step: assert property (@(posedge clk) disable iff (rst)
        (col != '0) |-> (col == $past(col) + 1'b1));

    a_r2_row_on_wrap: assert property (@(posedge clk) disable iff (rst)
        (row != $past(row)) |-> (col == '0));

    a_r3_hs_rise_pos: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync) |-> (col == sh.hs_on));

    a_r4_vs_rise_pos: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync) |-> (row == sh.vs_on));

    a_r5_pix_in_sync: assert property (@(posedge clk) disable iff (rst)
        pix_en |-> (hsync && !vsync));

    a_r6_cfg_frame_only: assert property (@(posedge clk) disable iff (rst)
        !(col == '0 && row == '0) |-> $stable(sh));

    a_r7_hs_empty: assert property (@(posedge clk) disable iff (rst)
        (sh.hs_off <= sh.hs_on) |-> !hsync);

    a_r7_vs_empty: assert property (@(posedge clk) disable iff (rst)
        (sh.vs_off <= sh.vs_on) |-> !vsync);

    a_r8_reset_origin: assert property (@(posedge clk)
        $fell(rst) |-> (col == '0 && row == '0));
endmodule

bind vsg_timing_gen vsg_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .col    (col),
    .row    (row),
    .hsync  (hsync),
    .vsync  (vsync),
    .pix_en (pix_en),
    .sh     (sh_cfg)
);

// File: tb/sim_vsg_timing_gen.sv
`timescale 1ns/1ps
module sim_vsg_timing_gen;
    import vsg_pkg::*;

    localparam int FR   = 16;
    localparam int ACT  = 8;
    localparam int LINE = 40;
    localparam vsg_cfg_t DEF = '{hs_on: 10'd4, hs_off: 10'd36, vs_on: 10'd3,
                                 vs_off: 10'd5, line_len: 10'd40};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       hsync, vsync, pix_en;
    logic [9:0] col, row;

    int n_chk = 0;
    int n_bad = 0;
    bit chk_on = 0;
    bit done = 0;

    int       m_col, m_row;
    vsg_cfg_t m_stg, m_sh;

    vsg_timing_gen #(
        .FRAME_ROWS(FR), .ACTIVE_ROWS(ACT), .DEF_LINE(LINE),
        .DEF_HS_ON(4), .DEF_HS_OFF(36), .DEF_VS_ON(3), .DEF_VS_OFF(5)
    ) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync(hsync), .vsync(vsync), .pix_en(pix_en), .col(col), .row(row)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int e_hs(int c, vsg_cfg_t s);
        return (c >= int'(s.hs_on) && c < int'(s.hs_off)) ? 1 : 0;
    endfunction
    function automatic int e_vs(int r, vsg_cfg_t s);
        return (r >= int'(s.vs_on) && r < int'(s.vs_off)) ? 1 : 0;
    endfunction
    function automatic int e_pe(int c, int r, vsg_cfg_t s);
        return (e_hs(c, s) == 1 && r >= int'(s.vs_off) && r < int'(s.vs_off) + ACT) ? 1 : 0;
    endfunction

    // reference model from the requirements, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_col = 0; m_row = 0; m_stg = DEF; m_sh = DEF;
        end else begin
            bit wrap, fw;
            wrap = (m_col + 1 >= int'(m_sh.line_len));
            fw   = wrap && (m_row == FR - 1);
            if (wrap) begin
                m_col = 0;
                m_row = (m_row == FR - 1) ? 0 : m_row + 1;
            end else begin
                m_col = m_col + 1;
            end
            if (fw) m_sh = m_stg;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_stg.hs_on[7:0]    = wr_data;
                    3'd1: m_stg.hs_off[7:0]   = wr_data;
                    3'd2: m_stg.vs_on[7:0]    = wr_data;
                    3'd3: m_stg.vs_off[7:0]   = wr_data;
                    3'd4: begin
                        m_stg.hs_on[9:8]  = wr_data[7:6];
                        m_stg.hs_off[9:8] = wr_data[5:4];
                        m_stg.vs_on[9:8]  = wr_data[3:2];
                        m_stg.vs_off[9:8] = wr_data[1:0];
                    end
                    3'd5: m_stg.line_len[7:0] = wr_data;
                    3'd6: m_stg.line_len[9:8] = wr_data[1:0];
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (chk_on && !done) begin
            chk("R1 col", int'(col), m_col);
            chk("R2 row", int'(row), m_row);
            chk("R3 hsync", int'(hsync), e_hs(m_col, m_sh));
            chk("R4 vsync", int'(vsync), e_vs(m_row, m_sh));
            chk("R5 pix_en", int'(pix_en), e_pe(m_col, m_row, m_sh));
        end
    end

    task automatic put(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_frame();
        do @(negedge clk); while (!(col == 10'd0 && row == 10'd0));
    endtask

    task automatic wait_line();
        do @(negedge clk); while (col != 10'd0);
    endtask

    task automatic count_line(input int len, output int h);
        h = 0;
        for (int i = 0; i < len; i++) begin
            if (hsync) h++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++; n_chk++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int h, vcnt, pcnt;
        void'($urandom(32'd4711));
        @(posedge clk);
        chk_on = 1;
        @(negedge clk);
        // R8: reset state
        chk("R8 reset col", int'(col), 0);
        chk("R8 reset row", int'(row), 0);
        chk("R8 reset pix_en", int'(pix_en), 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (2 * FR * LINE) @(negedge clk);

        // random reprogramming mixed with running frames
        for (int it = 0; it < 40; it++) begin
            int nw;
            nw = $urandom % 5;
            for (int k = 0; k < nw; k++) begin
                int a, d;
                a = $urandom % 8;
                case (a)
                    5: d = 8 + $urandom % 56;
                    6: d = 0;
                    4: d = ($urandom % 4 == 0) ? ($urandom % 256) : 0;
                    2, 3: d = $urandom % FR;
                    default: d = $urandom % 64;
                endcase
                put(a, d);
            end
            repeat ($urandom % 900) @(negedge clk);
        end

        // R8: reset mid-run restores defaults
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 col zero in reset", int'(col), 0);
        chk("R8 row zero in reset", int'(row), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 col after release", int'(col), 1);
        wait_line();
        count_line(LINE, h);
        chk("R8 default hsync width", h, 32);

        // R6: mid-frame write held until next frame
        wait_line();
        wait_line();
        put(1, 20);
        wait_line();
        count_line(LINE, h);
        chk("R6 old width kept mid-frame", h, 32);
        put(7, 8'hFF);
        wait_frame();
        count_line(LINE, h);
        chk("R6 new width at frame start", h, 16);
        wait_frame();
        count_line(LINE, h);
        chk("R6 addr 7 write ignored", h, 16);

        // R7: empty vertical window
        put(2, 6);
        put(3, 6);
        wait_frame();
        vcnt = 0; pcnt = 0;
        for (int i = 0; i < FR * LINE; i++) begin
            if (vsync) vcnt++;
            if (pix_en) pcnt++;
            @(negedge clk);
        end
        chk("R7 vsync stays low", vcnt, 0);
        chk("R5 pix_en count band rows 6..13", pcnt, ACT * 16);

        // R7: empty horizontal window
        put(0, 30);
        put(1, 30);
        wait_frame();
        wait_frame();
        count_line(LINE, h);
        chk("R7 hsync stays low", h, 0);

        // R3/R1: upper 2-bit fields, line 1000, hsync 272..543
        put(5, 8'hE8);
        put(6, 8'h03);
        put(0, 8'h10);
        put(1, 8'h20);
        put(4, 8'h60);
        wait_frame();
        count_line(1000, h);
        chk("R3 high-field hsync width", h, 272);
        chk("R1 line of 1000 wraps", int'(col), 0);
        chk("R2 row after long line", int'(row), 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule